// File: doc/BRIEF.md
# Receive Frame Queue with Overflow Policy

This block is a four-entry, 32-bit receive queue placed between a serial shifter and a bus read port. The shifter presents each completed frame as a one-cycle valid pulse with its data. The read side sees the oldest stored word and removes it with a pop strobe. Status outputs give the number of stored words and the slot the next pop reads from. Any of the four slots can be inspected directly without popping.

A full queue applies a configurable policy to an arriving word. With overwrite off, the word is dropped. With overwrite on, it replaces the most recently written slot. Either way a sticky overflow flag is raised. A drain flag tells the reader that data has been waiting. Each flag is cleared by a write-one pulse at its own bit position and has an enable bit at the same position that gates its request output.

A flush input empties the queue in one cycle. A bypass input shrinks the capacity to a single word, so the queue acts as a one-word pass-through. The occupancy controller is a three-state machine:
- Q_EMPTY: nothing is stored.
- Q_PARTIAL: some words are stored and there is room for more.
- Q_FULL: the queue holds its capacity.

Its transitions are:
- fill_first: Q_EMPTY to Q_PARTIAL on an accepted push, or to Q_FULL when the capacity is one.
- fill_last: Q_PARTIAL to Q_FULL when a push without a pop reaches capacity.
- drain_last: Q_PARTIAL to Q_EMPTY when a pop without a push removes the only word.
- drain_one: Q_FULL to Q_PARTIAL on a pop without a push, or to Q_EMPTY when the capacity is one.
- flush_all: any state to Q_EMPTY on flush.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset, fill_count and pop_ptr are 0, both flags and both requests are low, rd_data is 0, and every slot reads 0 through the debug port.
- R2: Accepted pushes are stored in arrival order. rd_data shows the oldest word whenever the queue is not empty, and each pop removes that word. fill_count changes by +1 for a push, by -1 for a pop, and by 0 for both, in the cycle after the strobe.
- R3: A pop while the queue is empty has no effect: fill_count and pop_ptr stay unchanged, and rd_data reads 0.
- R4: A push into a full queue without a pop, with cfg_overwrite=0, is dropped. fill_count stays at capacity and the stored words and their order are unchanged.
- R5: A push into a full queue without a pop, with cfg_overwrite=1, replaces the word in the most recently written slot. fill_count stays at capacity.
- R6: ovf_flag (status bit 0) rises in the cycle after a push arrives at a full queue without a pop. It stays high until a cycle with flag_clr[0]=1 and no new overflow event. A new overflow event takes priority over the clear.
- R7: A push and a pop in the same cycle on a full queue both take effect. This is not an overflow, and fill_count stays at capacity.
- R8: drain_flag (status bit 1) is set in the cycle after any cycle that starts with the queue non-empty. It holds until flag_clr[1]=1 is given in a cycle that starts with the queue empty.
- R9: ovf_req equals ovf_flag AND req_en[0]. drain_req equals drain_flag AND req_en[1].
- R10: q_flush sets fill_count and pop_ptr to 0 in the next cycle. It takes priority over a push or pop in the same cycle, and it leaves ovf_flag unchanged.
- R11: With cfg_bypass=1 the capacity is one word. A second push without a pop is an overflow, handled by the policy of R4 or R5.
- R12: pop_ptr is the slot index (0 to 3) of the oldest word. It advances by one per pop and wraps from 3 to 0.
- R13: dbg_data shows the raw contents of slot dbg_idx at any time, without popping and without changing any status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Completed frame from the shifter (push) |
| in_data | input | 32 | Frame data |
| rd_pop | input | 1 | Remove the oldest word |
| rd_data | output | 32 | Oldest word, 0 when empty |
| cfg_overwrite | input | 1 | 1: overwrite when full, 0: drop when full |
| cfg_bypass | input | 1 | 1: single-word capacity |
| q_flush | input | 1 | Empty the queue |
| flag_clr | input | 2 | Write-one-to-clear pulses, bit 0 overflow, bit 1 drain |
| req_en | input | 2 | Request enables, same bit positions as flag_clr |
| fill_count | output | 4 | Number of stored words |
| pop_ptr | output | 4 | Slot index of the oldest word |
| ovf_flag | output | 1 | Sticky overflow flag |
| drain_flag | output | 1 | Data-available flag |
| ovf_req | output | 1 | Gated overflow request |
| drain_req | output | 1 | Gated drain request |
| dbg_idx | input | 2 | Slot to inspect |
| dbg_data | output | 32 | Raw contents of the inspected slot |

## Verification
The assertions assume that cfg_bypass changes only while the queue is empty. The state machine tracks capacity reaching, not the count itself, so a capacity change with data held would leave state and count disagreeing. The assertions also assume that control inputs are known, not X, from the first edge after reset. The stimulus changes cfg_bypass only right after a flush and drives every input to a defined value at each falling edge. Pops on an empty queue, which the design must tolerate, are issued on purpose.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;

    localparam int FLAG_OVF   = 0;
    localparam int FLAG_DRAIN = 1;
    localparam int NFLAGS     = 2;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 2,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic          bypass,
    input  logic          overwrite,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output logic [CW-1:0] count,
    output logic          is_empty,
    output logic          is_full,
    output logic          ovf_evt
);
    q_state_e      state_q, state_d;
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] cap;
    logic          do_pop, acc, repl;

    assign cap    = bypass ? CW'(1) : CW'(DEPTH);
    assign do_pop = pop && !is_empty && !flush;
    assign acc    = push && !flush && (!is_full || do_pop);
    assign ovf_evt = push && !flush && is_full && !do_pop;
    assign repl   = ovf_evt && overwrite;

    assign wr_en  = acc || repl;
    assign wr_idx = repl ? (wr_ptr_q - 1'b1) : wr_ptr_q;
    assign rd_idx = rd_ptr_q;
    assign count  = count_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (acc) state_d = (cap == CW'(1)) ? Q_FULL : Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (acc && !do_pop && (count_q + CW'(1)) == cap)
                    state_d = Q_FULL;
                else if (do_pop && !acc && count_q == CW'(1))
                    state_d = Q_EMPTY;
            end
            Q_FULL: begin
                if (do_pop && !acc)
                    state_d = (cap == CW'(1)) ? Q_EMPTY : Q_PARTIAL;
            end
            default: state_d = Q_EMPTY;
        endcase
        if (flush) state_d = Q_EMPTY;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // state-decoded outputs
    always_comb begin
        is_empty = (state_q == Q_EMPTY);
        is_full  = (state_q == Q_FULL);
    end

    // pointers and occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (acc)    wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop) rd_ptr_q <= rd_ptr_q + 1'b1;
            if (acc && !do_pop)      count_q <= count_q + CW'(1);
            else if (do_pop && !acc) count_q <= count_q - CW'(1);
        end
    end

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    // R2
    state_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) == (state_q == Q_EMPTY));
    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0) && (rd_ptr_q == '0));
    // R4
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop && !overwrite && !flush)
        |=> (count_q == $past(count_q)) && (wr_ptr_q == $past(wr_ptr_q)));
    // R7
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && is_full && !flush) |=> count_q == $past(count_q));
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    input  logic [AW-1:0] dbg_idx,
    output logic [W-1:0]  rd_word,
    output logic [W-1:0]  dbg_word
);
    logic [DEPTH-1:0][W-1:0] slot_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (wr_en && wr_idx == AW'(i))
                slot_q[i] <= wr_data;
        end
    end

    assign rd_word  = slot_q[rd_idx];
    assign dbg_word = slot_q[dbg_idx];

    // R2
    slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slot_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf_evt,
    input  logic              nonempty,
    input  logic [NFLAGS-1:0] clr,
    input  logic [NFLAGS-1:0] en,
    output logic              ovf_flag,
    output logic              drain_flag,
    output logic              ovf_req,
    output logic              drain_req
);
    logic ovf_q, drain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q   <= 1'b0;
            drain_q <= 1'b0;
        end else begin
            ovf_q   <= ovf_evt  || (ovf_q   && !clr[FLAG_OVF]);
            drain_q <= nonempty || (drain_q && !clr[FLAG_DRAIN]);
        end
    end

    assign ovf_flag   = ovf_q;
    assign drain_flag = drain_q;
    assign ovf_req    = ovf_q   && en[FLAG_OVF];
    assign drain_req  = drain_q && en[FLAG_DRAIN];

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr[FLAG_OVF]) |=> ovf_flag);
    // R8
    drain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nonempty |=> drain_flag);
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    parameter int STW   = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      in_data,
    input  logic              rd_pop,
    output logic [W-1:0]      rd_data,
    input  logic              cfg_overwrite,
    input  logic              cfg_bypass,
    input  logic              q_flush,
    input  logic [NFLAGS-1:0] flag_clr,
    input  logic [NFLAGS-1:0] req_en,
    output logic [STW-1:0]    fill_count,
    output logic [STW-1:0]    pop_ptr,
    output logic              ovf_flag,
    output logic              drain_flag,
    output logic              ovf_req,
    output logic              drain_req,
    input  logic [AW-1:0]     dbg_idx,
    output logic [W-1:0]      dbg_data
);
    logic          wr_en, is_empty, is_full, ovf_evt;
    logic [AW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] count;
    logic [W-1:0]  rd_word;

    rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push(in_valid), .pop(rd_pop), .flush(q_flush),
        .bypass(cfg_bypass), .overwrite(cfg_overwrite),
        .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
        .count(count), .is_empty(is_empty), .is_full(is_full),
        .ovf_evt(ovf_evt)
    );

    rxq_store #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(in_data),
        .rd_idx(rd_idx), .dbg_idx(dbg_idx),
        .rd_word(rd_word), .dbg_word(dbg_data)
    );

    rxq_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .ovf_evt(ovf_evt), .nonempty(!is_empty),
        .clr(flag_clr), .en(req_en),
        .ovf_flag(ovf_flag), .drain_flag(drain_flag),
        .ovf_req(ovf_req), .drain_req(drain_req)
    );

    assign rd_data    = is_empty ? '0 : rd_word;
    assign fill_count = {{(STW-CW){1'b0}}, count};
    assign pop_ptr    = {{(STW-AW){1'b0}}, rd_idx};

    // R3
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> (rd_data == '0));
    // R5
    repl_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && cfg_overwrite && is_full) |=> fill_count == $past(fill_count));
endmodule

// File: tb/sim_rx_frame_queue.sv
`timescale 1ns/1ps
module sim_rx_frame_queue;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         rd_pop = 1'b0;
    logic [W-1:0] rd_data;
    logic         cfg_overwrite = 1'b0;
    logic         cfg_bypass = 1'b0;
    logic         q_flush = 1'b0;
    logic [1:0]   flag_clr = 2'b00;
    logic [1:0]   req_en = 2'b00;
    logic [3:0]   fill_count, pop_ptr;
    logic         ovf_flag, drain_flag, ovf_req, drain_req;
    logic [1:0]   dbg_idx = 2'd0;
    logic [W-1:0] dbg_data;

    always #2 clk = ~clk;

    rx_frame_queue u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .rd_pop(rd_pop), .rd_data(rd_data), .cfg_overwrite(cfg_overwrite),
        .cfg_bypass(cfg_bypass), .q_flush(q_flush), .flag_clr(flag_clr),
        .req_en(req_en), .fill_count(fill_count), .pop_ptr(pop_ptr),
        .ovf_flag(ovf_flag), .drain_flag(drain_flag), .ovf_req(ovf_req),
        .drain_req(drain_req), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [W-1:0] mm [4];
    logic [W-1:0] exp_q [$];
    int mc = 0, mw = 0, mr = 0;
    bit movf = 1'b0, mdrain = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic status_chk();
        chk(fill_count == 4'(mc), "R2 fill_count", W'(fill_count), W'(mc));
        chk(pop_ptr == 4'(mr), "R12 pop_ptr", W'(pop_ptr), W'(mr));
        chk(ovf_flag == movf, "R6 ovf_flag", W'(ovf_flag), W'(movf));
        chk(drain_flag == mdrain, "R8 drain_flag", W'(drain_flag), W'(mdrain));
        chk(ovf_req == (movf && req_en[0]), "R9 ovf_req", W'(ovf_req), W'(movf && req_en[0]));
        chk(drain_req == (mdrain && req_en[1]), "R9 drain_req", W'(drain_req), W'(mdrain && req_en[1]));
    endtask

    task automatic dbg_chk();
        for (int i = 0; i < 4; i++) begin
            dbg_idx = 2'(i);
            #0.1;
            chk(dbg_data == mm[i], "R13 debug slot", dbg_data, mm[i]);
        end
    endtask

    // driver: one cycle of stimulus; the scoreboard queue holds the expected pop order
    task automatic cyc(input bit push, input logic [W-1:0] d, input bit pop, input bit fl, input logic [1:0] clr);
        int cap = cfg_bypass ? 1 : 4;
        bit dp = pop && (mc > 0) && !fl;
        bit evt = push && !fl && (mc >= cap) && !dp;
        if (pop && !fl) begin
            if (mc > 0) chk(rd_data == exp_q[0], "R2 head word", rd_data, exp_q[0]);
            else        chk(rd_data == '0, "R3 empty read", rd_data, '0);
        end
        in_valid = push; in_data = d; rd_pop = pop; q_flush = fl; flag_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; rd_pop = 1'b0; q_flush = 1'b0; flag_clr = 2'b00;
        mdrain = (mc != 0) || (mdrain && !clr[1]);
        if (evt) movf = 1'b1;
        else if (clr[0]) movf = 1'b0;
        if (fl) begin
            mc = 0; mw = 0; mr = 0; exp_q.delete();
        end else begin
            if (dp) begin
                void'(exp_q.pop_front()); mr = (mr + 1) % 4; mc--;
            end
            if (push && !evt) begin
                mm[mw] = d; mw = (mw + 1) % 4; exp_q.push_back(d); mc++;
            end else if (push && cfg_overwrite) begin
                mm[(mw + 3) % 4] = d; exp_q[exp_q.size() - 1] = d;
            end
        end
        status_chk();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mm[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == '0, "R1 rd_data", rd_data, '0);
        status_chk();
        dbg_chk();

        // R3 pop on empty
        cyc(0, '0, 1, 0, 2'b00);

        // R2 basic order, mixed push/pop
        cyc(1, 32'h1111_0001, 0, 0, 2'b00);
        cyc(1, 32'h2222_0002, 0, 0, 2'b00);
        cyc(1, 32'h3333_0003, 1, 0, 2'b00);
        cyc(0, '0, 1, 0, 2'b00);
        cyc(0, '0, 1, 0, 2'b00);
        cyc(0, '0, 1, 0, 2'b00);
        dbg_chk();

        // R8 drain flag cleared once empty
        cyc(0, '0, 0, 0, 2'b10);

        // R4 drop when full
        cfg_overwrite = 1'b0;
        for (int i = 0; i < 5; i++) cyc(1, 32'hA000_0000 + W'(i), 0, 0, 2'b00);
        dbg_chk();
        // R9 request gating
        req_en = 2'b10; #0.1; status_chk();
        req_en = 2'b01; #0.1; status_chk();
        req_en = 2'b11;
        // R6 clear while an overflow recurs: set wins
        cyc(1, 32'hDEAD_0001, 0, 0, 2'b01);
        // R6 clear
        cyc(0, '0, 0, 0, 2'b01);
        // R7 push and pop on full
        cyc(1, 32'hB000_0007, 1, 0, 2'b00);
        for (int i = 0; i < 4; i++) cyc(0, '0, 1, 0, 2'b00);

        // R5 overwrite when full
        cyc(0, '0, 0, 1, 2'b00);
        cfg_overwrite = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1, 32'hC000_0000 + W'(i), 0, 0, 2'b00);
        cyc(1, 32'hC0DE_0E0E, 0, 0, 2'b00);
        dbg_chk();
        for (int i = 0; i < 4; i++) cyc(0, '0, 1, 0, 2'b00);

        // R10 flush with push, ovf preserved
        cyc(1, 32'hE000_0001, 0, 0, 2'b00);
        cyc(1, 32'hE000_0002, 0, 1, 2'b00);
        cyc(0, '0, 1, 0, 2'b00);

        // R11 bypass: single-word capacity
        cyc(0, '0, 0, 1, 2'b01);
        cfg_bypass = 1'b1;
        cfg_overwrite = 1'b0;
        cyc(1, 32'hF000_0001, 0, 0, 2'b00);
        cyc(1, 32'hF000_0002, 0, 0, 2'b00);
        cyc(0, '0, 1, 0, 2'b00);
        cfg_overwrite = 1'b1;
        cyc(1, 32'hF000_0003, 0, 0, 2'b00);
        cyc(1, 32'hF000_0004, 0, 0, 2'b00);
        cyc(1, 32'hF000_0005, 1, 0, 2'b00);
        cyc(0, '0, 1, 0, 2'b00);
        cyc(0, '0, 0, 1, 2'b00);
        cfg_bypass = 1'b0;

        // R12 pointer wrap over many pops
        for (int i = 0; i < 10; i++) begin
            cyc(1, 32'h5000_0000 + W'(i), 0, 0, 2'b00);
            cyc(0, '0, 1, 0, 2'b00);
        end
        dbg_chk();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule